// File: doc/BRIEF.md
# Card Data-Phase Transfer Sequencer

This block paces the data phase of a memory-card host controller. When software issues a transfer it supplies a kind (one block, many blocks, or an unframed stream), a block length in bytes and a 16-bit block count. These settings are latched at `start`. The block then accepts 32-bit words from the card-side receive logic over a valid/ready stream. It counts the bytes in each block and the blocks in the transaction, and decides when the transaction is over.

Each accepted word is parked in a one-word holding register. The latched path-select bit decides how the word leaves. With the bit set, the word goes out through a request/acknowledge pair for a DMA engine. With the bit clear, it goes through a polled register with a valid flag and a pop strobe. The stream input sees back-pressure whenever the holding register is occupied. `in_ready` is low while a word waits or while the block is idle. The sender must hold `in_data` steady until a cycle with both `in_valid` and `in_ready` high.

A multi-block transfer with a non-zero count ends by itself after the last block. A count of zero makes it open-ended: it runs until a stop request and then closes at a block boundary. A sticky end flag can raise an interrupt through an enable input. An error input aborts at once. If that error cuts short a multi-block transfer, the block raises a flag that says a stop command must still be sent.

Top module: `card_xfer_seq`

## Requirements
- R1: After reset, `busy`, `in_ready`, `dma_req`, `reg_valid`, `blk_done`, `xfer_done`, `end_flag`, `err_flag`, `stop_needed` and `irq` are 0, and `blk_count` is 0.
- R2: A word is accepted only in a cycle with `in_valid` and `in_ready` both high. `in_ready` is high only while `busy` is high, the holding register is empty and `err_in` is low.
- R3: Each accepted word adds 4 to the byte count. A block completes on the word that brings the count to `cfg_blk_len` or beyond. The next cycle then shows a one-cycle `blk_done`, and `blk_count` goes up by one. Stream transfers never complete blocks.
- R4: `cfg_kind` code 0 (single) ignores `cfg_blk_cnt` and ends after one block. Code 3 behaves the same way.
- R5: `cfg_kind` code 1 (multi) with a non-zero count ends after exactly that many blocks. `stop_req` has no effect on it.
- R6: The cycle after the final word is accepted shows a one-cycle `xfer_done`, and `busy` is low in that same cycle.
- R7: `end_flag` is set when a transfer ends normally and stays set until the next `start`. `irq` is high exactly when `end_flag` and `irq_en` are both high.
- R8: `err_in` high while busy aborts the transfer at the next edge. After that edge `busy` is low, `err_flag` is set (sticky until `start`), no `xfer_done` is given, and the holding register is emptied. `err_in` while idle has no effect.
- R9: With `cfg_dma_sel`=1 a held word shows on `out_data` with `dma_req` and leaves on `dma_ack`. With `cfg_dma_sel`=0 it shows with `reg_valid` and leaves on `reg_pop`. Words leave in the order they were accepted, and the two valid outputs are never high together.
- R10: In multi mode with count 0, a `stop_req` that arrives mid-block ends the transfer when that block completes. If no block is in progress, the transfer ends at the next edge.
- R11: `cfg_kind` code 2 (stream) ends at the edge where `stop_req` is seen. A word accepted at that same edge still counts.
- R12: An abort during a multi-block transfer sets `stop_needed`, which stays set until `start`. An abort during a single-block transfer leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_kind | input | 2 | Transfer kind: 0 single, 1 multi, 2 stream, 3 as single |
| cfg_blk_len | input | LEN_W | Bytes per block |
| cfg_blk_cnt | input | CNT_W | Blocks to move; 0 means open-ended |
| cfg_dma_sel | input | 1 | 1 routes words to the DMA handshake, 0 to the polled register |
| irq_en | input | 1 | Interrupt enable mask for the end flag |
| start | input | 1 | Begins a transfer when idle; latches the configuration |
| stop_req | input | 1 | Stop request for open-ended and stream transfers |
| err_in | input | 1 | Error indication; aborts a running transfer |
| in_valid | input | 1 | Incoming word is valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DW | Incoming data word |
| dma_req | output | 1 | Held word waiting for the DMA engine |
| dma_ack | input | 1 | DMA engine takes the held word |
| reg_valid | output | 1 | Held word waiting in the polled register |
| reg_pop | input | 1 | Software takes the polled word |
| out_data | output | DW | Held word |
| busy | output | 1 | Transfer in progress |
| blk_done | output | 1 | One-cycle block completion pulse |
| xfer_done | output | 1 | One-cycle transfer completion pulse |
| blk_count | output | CNT_W | Blocks completed since the last start |
| end_flag | output | 1 | Sticky end-of-transfer status |
| err_flag | output | 1 | Sticky error status |
| stop_needed | output | 1 | A stop command must still be issued |
| irq | output | 1 | End flag gated by irq_en |

## Verification
All results are registered one edge after their cause. `blk_done`, `xfer_done`, `end_flag` and the fall of `busy` appear in the cycle after the edge that accepts the closing word. The abort effects of `err_in` show one edge after it is sampled. `in_ready`, `dma_req` and `reg_valid` change one edge after an accept or a take. `irq` follows `end_flag` and `irq_en` with no added delay. The bench drives inputs and samples outputs on the falling clock edge. It counts a word as taken when it sees `in_ready` high at the falling edge before the accepting rising edge. It therefore always reads a result half a cycle after the edge that produced it.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef enum logic [1:0] {
    XK_SINGLE = 2'd0,
    XK_MULTI  = 2'd1,
    XK_STREAM = 2'd2,
    XK_RSVD   = 2'd3
  } xfer_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/xfer_byte_ctr.sv
// Byte position inside the current block; flags the word that closes it.
module xfer_byte_ctr #(
  parameter int DW    = 32,
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [LEN_W-1:0] blk_len,
  output logic [LEN_W-1:0] byte_cnt,
  output logic             blk_end
);
  localparam int STEP = DW / 8;

  logic [LEN_W:0] nxt;

  assign nxt     = {1'b0, byte_cnt} + (LEN_W+1)'(STEP);
  assign blk_end = adv && (nxt >= {1'b0, blk_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_cnt <= '0;
    else if (clr)     byte_cnt <= '0;
    else if (adv)     byte_cnt <= blk_end ? '0 : nxt[LEN_W-1:0];
  end
endmodule

// File: rtl/xfer_blk_ctr.sv
// Completed-block count and last-block detection for counted transfers.
module xfer_blk_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] done_cnt,
  output logic             at_last
);
  logic [CNT_W-1:0] nxt;

  assign nxt     = done_cnt + CNT_W'(1);
  assign at_last = inc && (nxt == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    done_cnt <= '0;
    else if (clr)  done_cnt <= '0;
    else if (inc)  done_cnt <= nxt;
  end
endmodule

// File: rtl/xfer_hold.sv
// One-word holding register steered to the DMA handshake or the polled register.
module xfer_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          dma_sel,
  input  logic          dma_ack,
  input  logic          reg_pop,
  output logic          full,
  output logic [DW-1:0] dout,
  output logic          dma_req,
  output logic          reg_valid
);
  logic take;

  assign dma_req   = full && dma_sel;
  assign reg_valid = full && !dma_sel;
  assign take      = dma_sel ? (dma_ack && full) : (reg_pop && full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (flush) begin
      full <= 1'b0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/card_xfer_seq.sv
module card_xfer_seq
  import xfer_seq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_kind,
  input  logic [LEN_W-1:0] cfg_blk_len,
  input  logic [CNT_W-1:0] cfg_blk_cnt,
  input  logic             cfg_dma_sel,
  input  logic             irq_en,
  input  logic             start,
  input  logic             stop_req,
  input  logic             err_in,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             dma_req,
  input  logic             dma_ack,
  output logic             reg_valid,
  input  logic             reg_pop,
  output logic [DW-1:0]    out_data,
  output logic             busy,
  output logic             blk_done,
  output logic             xfer_done,
  output logic [CNT_W-1:0] blk_count,
  output logic             end_flag,
  output logic             err_flag,
  output logic             stop_needed,
  output logic             irq
);
  seq_state_e       state_q;
  xfer_kind_e       kind_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dma_q;
  logic             stop_pend_q;
  logic             blk_done_q;
  logic             xfer_done_q;
  logic             end_q;
  logic             err_q;
  logic             stopn_q;

  logic             run;
  logic             go;
  logic             abort;
  logic             acc;
  logic             hold_full;
  logic [LEN_W-1:0] byte_cnt;
  logic             blk_end;
  logic             blk_fin;
  logic             at_last;
  logic             stop_seen;
  logic             fin;

  assign run       = (state_q == ST_RUN);
  assign go        = !run && start;
  assign abort     = run && err_in;
  assign in_ready  = run && !hold_full && !err_in;
  assign acc       = in_valid && in_ready;
  assign blk_fin   = blk_end && (kind_q != XK_STREAM);
  assign stop_seen = stop_pend_q || stop_req;

  xfer_byte_ctr #(.DW(DW), .LEN_W(LEN_W)) u_bytes (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (go),
    .adv      (acc),
    .blk_len  (len_q),
    .byte_cnt (byte_cnt),
    .blk_end  (blk_end)
  );

  xfer_blk_ctr #(.CNT_W(CNT_W)) u_blocks (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (go),
    .inc      (blk_fin),
    .target   (cnt_q),
    .done_cnt (blk_count),
    .at_last  (at_last)
  );

  xfer_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (abort),
    .load      (acc),
    .din       (in_data),
    .dma_sel   (dma_q),
    .dma_ack   (dma_ack),
    .reg_pop   (reg_pop),
    .full      (hold_full),
    .dout      (out_data),
    .dma_req   (dma_req),
    .reg_valid (reg_valid)
  );

  // Termination rule per transfer kind.
  always_comb begin
    unique case (kind_q)
      XK_MULTI: begin
        if (cnt_q != '0) fin = at_last;
        else             fin = (blk_fin && stop_seen) ||
                               (stop_seen && (byte_cnt == '0) && !acc);
      end
      XK_STREAM: fin = stop_seen;
      default:   fin = blk_fin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= XK_SINGLE;
      len_q       <= '0;
      cnt_q       <= '0;
      dma_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      blk_done_q  <= 1'b0;
      xfer_done_q <= 1'b0;
      end_q       <= 1'b0;
      err_q       <= 1'b0;
      stopn_q     <= 1'b0;
    end else begin
      blk_done_q  <= 1'b0;
      xfer_done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q     <= ST_RUN;
            kind_q      <= xfer_kind_e'(cfg_kind);
            len_q       <= cfg_blk_len;
            cnt_q       <= cfg_blk_cnt;
            dma_q       <= cfg_dma_sel;
            stop_pend_q <= 1'b0;
            end_q       <= 1'b0;
            err_q       <= 1'b0;
            stopn_q     <= 1'b0;
          end
        end
        ST_RUN: begin
          if (err_in) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
            stopn_q <= (kind_q == XK_MULTI);
          end else begin
            if (stop_req) stop_pend_q <= 1'b1;
            if (blk_fin)  blk_done_q  <= 1'b1;
            if (fin) begin
              state_q     <= ST_IDLE;
              xfer_done_q <= 1'b1;
              end_q       <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = run;
  assign blk_done    = blk_done_q;
  assign xfer_done   = xfer_done_q;
  assign end_flag    = end_q;
  assign err_flag    = err_q;
  assign stop_needed = stopn_q;
  assign irq         = end_q && irq_en;
endmodule

// File: rtl/card_xfer_seq_chk.sv
module card_xfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic err_in,
  input logic in_ready,
  input logic dma_req,
  input logic reg_valid,
  input logic busy,
  input logic blk_done,
  input logic xfer_done,
  input logic end_flag,
  input logic err_flag
);
  a_r2_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  a_r2_ready_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req || reg_valid) |-> !in_ready);

  a_r9_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && reg_valid));

  a_r3_blk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  a_r7_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> xfer_done);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_in) |=> (!busy && err_flag && !xfer_done && !dma_req && !reg_valid));
endmodule

bind card_xfer_seq card_xfer_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_in    (err_in),
  .in_ready  (in_ready),
  .dma_req   (dma_req),
  .reg_valid (reg_valid),
  .busy      (busy),
  .blk_done  (blk_done),
  .xfer_done (xfer_done),
  .end_flag  (end_flag),
  .err_flag  (err_flag)
);

// File: tb/card_xfer_seq_bench.sv
`timescale 1ns/1ps
module card_xfer_seq_bench;
  localparam int DW = 32, LEN_W = 12, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_kind = '0;
  logic [LEN_W-1:0] cfg_blk_len = '0;
  logic [CNT_W-1:0] cfg_blk_cnt = '0;
  logic cfg_dma_sel = 1'b0, irq_en = 1'b0, start = 1'b0, stop_req = 1'b0, err_in = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic dma_req, dma_ack = 1'b0, reg_valid, reg_pop = 1'b0;
  logic [DW-1:0] out_data;
  logic busy, blk_done, xfer_done, end_flag, err_flag, stop_needed, irq;
  logic [CNT_W-1:0] blk_count;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  card_xfer_seq #(.DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_card_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_blk_len(cfg_blk_len),
    .cfg_blk_cnt(cfg_blk_cnt), .cfg_dma_sel(cfg_dma_sel), .irq_en(irq_en),
    .start(start), .stop_req(stop_req), .err_in(err_in), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .dma_req(dma_req), .dma_ack(dma_ack),
    .reg_valid(reg_valid), .reg_pop(reg_pop), .out_data(out_data), .busy(busy),
    .blk_done(blk_done), .xfer_done(xfer_done), .blk_count(blk_count),
    .end_flag(end_flag), .err_flag(err_flag), .stop_needed(stop_needed), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d expected <150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] len;
    logic [15:0] cnt;
    logic        dma;
    logic [15:0] stop_b;
    logic [15:0] stop_w;
    logic [15:0] exp_blk;
    logic [15:0] exp_w;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{2'd0, 12'd16, 16'd0, 1'b0, 16'd0, 16'd0, 16'd1, 16'd4},  // R4 single
    '{2'd0, 12'd8,  16'd5, 1'b1, 16'd0, 16'd0, 16'd1, 16'd2},  // R4 count ignored
    '{2'd1, 12'd8,  16'd3, 1'b1, 16'd0, 16'd0, 16'd3, 16'd6},  // R5
    '{2'd1, 12'd4,  16'd5, 1'b0, 16'd0, 16'd0, 16'd5, 16'd5},  // R5 one-word blocks
    '{2'd1, 12'd12, 16'd2, 1'b0, 16'd1, 16'd0, 16'd2, 16'd6},  // R5 stop ignored
    '{2'd1, 12'd8,  16'd0, 1'b1, 16'd2, 16'd0, 16'd2, 16'd4},  // R10 stop between blocks
    '{2'd2, 12'd16, 16'd0, 1'b0, 16'd0, 16'd7, 16'd0, 16'd7},  // R11 stream
    '{2'd1, 12'd16, 16'd0, 1'b0, 16'd0, 16'd6, 16'd2, 16'd8},  // R10 stop mid-block
    '{2'd3, 12'd8,  16'd4, 1'b1, 16'd0, 16'd0, 16'd1, 16'd2}   // R4 code 3
  };

  task automatic run_vec(input vec_t v);
    int blocks = 0, words = 0, got = 0, n = 0;
    bit done = 0, sent = 0;
    string tg;
    if (v.kind == 2'd2) tg = "R11";
    else if (v.kind != 2'd1) tg = "R4";
    else if (v.cnt != 0) tg = "R5";
    else tg = "R10";
    @(negedge clk);
    cfg_kind = v.kind; cfg_blk_len = v.len; cfg_blk_cnt = v.cnt; cfg_dma_sel = v.dma;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1;
    while (!done && n < 3000) begin
      n++;
      if (blk_done) blocks++;
      if (xfer_done) done = 1;
      dma_ack = 1'b0; reg_pop = 1'b0;
      if (v.dma ? dma_req : reg_valid) begin
        check(out_data == DW'(got), "R9 order", int'(out_data), got);
        got++;
        if (v.dma) dma_ack = 1'b1; else reg_pop = 1'b1;
      end
      if (in_ready) begin
        in_data = DW'(words);
        words++;
      end
      stop_req = 1'b0;
      if (!sent && ((v.stop_b != 0 && blocks == int'(v.stop_b)) ||
                    (v.stop_w != 0 && words == int'(v.stop_w)))) begin
        stop_req = 1'b1;
        sent = 1;
      end
      if (!done) @(negedge clk);
    end
    in_valid = 1'b0;
    stop_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      dma_ack = 1'b0; reg_pop = 1'b0;
      if (v.dma ? dma_req : reg_valid) begin
        check(out_data == DW'(got), "R9 drain order", int'(out_data), got);
        got++;
        if (v.dma) dma_ack = 1'b1; else reg_pop = 1'b1;
      end
    end
    @(negedge clk);
    dma_ack = 1'b0; reg_pop = 1'b0;
    check(done, {tg, " R6 xfer_done seen"}, int'(done), 1);
    check(blocks == int'(v.exp_blk), {tg, " R3 blk_done pulses"}, blocks, int'(v.exp_blk));
    check(words == int'(v.exp_w), {tg, " R2 words accepted"}, words, int'(v.exp_w));
    check(got == int'(v.exp_w), "R9 words delivered", got, int'(v.exp_w));
    check(blk_count == v.exp_blk, {tg, " R3 blk_count"}, int'(blk_count), int'(v.exp_blk));
    check(!busy && end_flag, "R6 R7 idle with end_flag", int'({busy, end_flag}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, in_ready, dma_req, reg_valid, blk_done, xfer_done} == 6'b0,
          "R1 handshake/status", int'({busy, in_ready, dma_req, reg_valid, blk_done, xfer_done}), 0);
    check({end_flag, err_flag, stop_needed, irq} == 4'b0, "R1 flags",
          int'({end_flag, err_flag, stop_needed, irq}), 0);
    check(blk_count == 0, "R1 blk_count", int'(blk_count), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R7 interrupt gating
    irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R7 irq masked", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R7 irq enabled", int'(irq), 1);

    // R8 err_in while idle has no effect
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    @(negedge clk);
    check(err_flag == 1'b0 && end_flag == 1'b1, "R8 idle error ignored", int'({err_flag, end_flag}), 1);

    // R8 R12 abort during multi-block: word held, not taken
    cfg_kind = 2'd1; cfg_blk_len = 12'd16; cfg_blk_cnt = 16'd4; cfg_dma_sel = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(end_flag == 1'b0 && irq == 1'b0, "R7 start clears end_flag", int'({end_flag, irq}), 0);
    in_valid = 1'b1; in_data = 32'hA5;
    @(negedge clk);
    in_valid = 1'b0;
    check(reg_valid == 1'b1, "R9 word held in register path", int'(reg_valid), 1);
    @(negedge clk);
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    check(!busy && err_flag, "R8 abort to idle", int'({busy, err_flag}), 1);
    check(!xfer_done && !end_flag, "R8 no done on abort", int'({xfer_done, end_flag}), 0);
    check(!reg_valid && !dma_req, "R8 holding flushed", int'({reg_valid, dma_req}), 0);
    check(stop_needed == 1'b1, "R12 stop needed after multi abort", int'(stop_needed), 1);
    repeat (2) @(negedge clk);
    check(err_flag && stop_needed, "R8 R12 flags sticky", int'({err_flag, stop_needed}), 3);

    // R12 abort during single block leaves stop_needed clear
    cfg_kind = 2'd0; cfg_blk_len = 12'd16;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!err_flag && !stop_needed, "R8 R12 start clears flags", int'({err_flag, stop_needed}), 0);
    err_in = 1'b1;
    @(negedge clk);
    err_in = 1'b0;
    check(err_flag && !stop_needed && !busy, "R12 single abort no stop",
          int'({err_flag, stop_needed, busy}), 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule